// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block gives a processor register access to a bank of general-purpose pins. Each pin owns one configuration word. That word enables the pin's output path, its input path, its output buffer and its interrupt, and it selects one of five trigger conditions. Two shared registers hold the sampled input levels and the output data for the whole bank. A third shared register holds one pending-interrupt bit per pin, and software clears these bits by writing ones. The bank also has a single interrupt line, which is high whenever any pending bit is set.

Pad inputs pass through a two-flop synchronizer before they are sampled or checked for edges. The register port is a plain synchronous port with separate write and read strobes and a byte address. A read returns its data on the clock edge that accepts it. The bank width is set by a parameter. A request for more than 32 pins is limited to 32. Pins above the bank width read as zero and never drive their pads.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration word, the output data, every pending bit and the read data are zero, and `irq`, `pin_out` and `pin_oe` are all zero.
- R2: The pin count is `PIN_REQ`, limited to the range 1 to 32. For a pin at or above that count, its configuration offset reads zero and ignores writes, its bits read zero in the status, input and output registers, and its `pin_out` and `pin_oe` stay zero.
- R3: The configuration word of pin i sits at byte offset 4*i and has these fields: bit 0 output enable, bit 1 input enable, bit 2 output-buffer enable, bit 3 interrupt enable, bits 7:5 trigger code. Bit 4 and bits 31:8 read as zero.
- R4: `pin_oe[i]` is high exactly when both the output-enable bit and the output-buffer-enable bit of pin i are set, starting from the edge that writes the word.
- R5: Offset 0x88 is a read/write register of output data with one bit per pin. `pin_out` follows it from the edge of the write.
- R6: Offset 0x84 is read-only and returns the synchronized input levels. A pad change can be seen in a read accepted on the third clock edge after the change, and cannot be seen in a read accepted on an earlier edge.
- R7: Trigger code 0 (high level) and trigger code 1 (low level) set the pin's pending bit on every edge at which the synchronized level is active. This includes the edge straight after a clear.
- R8: Trigger code 2 (rising edge), trigger code 3 (falling edge) and trigger code 4 (either edge) set the pending bit once per matching transition of the synchronized level. The bit is set on the third clock edge after the pad changes.
- R9: A pending bit is never set while the pin's interrupt-enable bit is clear, and trigger codes 5, 6 and 7 never set it.
- R10: Offset 0x80 holds the pending bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit happen on the same edge, the set wins.
- R11: `irq` is the OR of all pending bits.
- R12: The read data is registered on the edge that accepts a read and is held until the next read. Offsets that are not word-aligned, and aligned offsets that are not mapped, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_rd | input | 1 | Read strobe for the register port |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Pad output data |
| pin_oe | output | 32 | Pad drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
Each result has a fixed latency:
- A configuration write or an output-data write reaches `pin_oe` or `pin_out` on the edge that accepts it.
- A read answers on the edge that accepts it.
- A pad change appears in the input register two edges later.
- A pad change sets a pending bit, and so `irq`, three edges later.

The bench drives every input on the falling clock edge and samples on a later falling edge. A cycle-accurate model in the bench, written from the requirements, advances on every rising edge, so each compare lands on the cycle its result is due. The directed cases also probe one cycle early, where the old value must still be seen.

// File: rtl/gpio_ctrl_pkg.sv
// Shared constants, the per-pin configuration type and helpers for the GPIO
// controller. Assumes a bank of at most 32 pins and 32-bit data words.
package gpio_ctrl_pkg;

    localparam int MAX_PINS = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_INVAL  = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_OUTVAL = 8'h88;

    // Trigger codes; values 5..7 are inert.
    localparam logic [2:0] TRIG_LVL_HI = 3'd0;
    localparam logic [2:0] TRIG_LVL_LO = 3'd1;
    localparam logic [2:0] TRIG_RISE   = 3'd2;
    localparam logic [2:0] TRIG_FALL   = 3'd3;
    localparam logic [2:0] TRIG_BOTH   = 3'd4;

    typedef struct packed {
        logic [2:0] trig;
        logic       irq_en;
        logic       buf_en;
        logic       in_en;
        logic       out_en;
    } pin_cfg_t;

    // Mask with one bit set for each implemented pin.
    function automatic logic [MAX_PINS-1:0] pin_mask(int n);
        logic [MAX_PINS-1:0] m;
        m = '0;
        for (int k = 0; k < MAX_PINS; k++) begin
            if (k < n) m[k] = 1'b1;
        end
        return m;
    endfunction

    // Unpack a bus word into a configuration record.
    function automatic pin_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        pin_cfg_t c;
        c.trig   = w[7:5];
        c.irq_en = w[3];
        c.buf_en = w[2];
        c.in_en  = w[1];
        c.out_en = w[0];
        return c;
    endfunction

    // Pack a configuration record into its read-back word.
    function automatic logic [DATA_W-1:0] cfg_to_word(pin_cfg_t c);
        return {24'd0, c.trig, 1'b0, c.irq_en, c.buf_en, c.in_en, c.out_en};
    endfunction

    // True when the trigger condition holds for the current and previous level.
    function automatic logic trig_match(logic [2:0] code, logic cur, logic prv);
        logic hit;
        case (code)
            TRIG_LVL_HI: hit = cur;
            TRIG_LVL_LO: hit = !cur;
            TRIG_RISE:   hit = cur && !prv;
            TRIG_FALL:   hit = !cur && prv;
            TRIG_BOTH:   hit = cur ^ prv;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pad inputs, plus one more stage that keeps
// the previous synchronized level for edge detection.
// Assumes: pad inputs are asynchronous; pins at or above NPIN are forced to 0.
module gpio_in_sync
    import gpio_ctrl_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MAX_PINS-1:0] pad_in,
    output logic [MAX_PINS-1:0] level_q,
    output logic [MAX_PINS-1:0] last_q
);

    localparam logic [MAX_PINS-1:0] LIVE = pin_mask(NPIN);

    logic [MAX_PINS-1:0] meta_q;

    // Synchronizer chain and previous-level stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            level_q <= '0;
            last_q  <= '0;
        end else begin
            meta_q  <= pad_in & LIVE;
            level_q <= meta_q;
            last_q  <= level_q;
        end
    end

endmodule

// File: rtl/gpio_event_det.sv
// Per-pin trigger detection and sticky pending bits with write-one clear.
// Assumes: level/last come from the synchronizer; clr_mask is a one-cycle
// pulse pattern from the register port. A set beats a clear on the same edge.
module gpio_event_det
    import gpio_ctrl_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  pin_cfg_t [MAX_PINS-1:0]       cfg,
    input  logic [MAX_PINS-1:0]           level,
    input  logic [MAX_PINS-1:0]           last,
    input  logic [MAX_PINS-1:0]           clr_mask,
    output logic [MAX_PINS-1:0]           pend
);

    for (genvar i = 0; i < MAX_PINS; i++) begin : g_pin
        if (i < NPIN) begin : g_live
            logic hit;
            logic pend_q;

            assign hit = cfg[i].irq_en && trig_match(cfg[i].trig, level[i], last[i]);

            // Pending bit: set on hit, cleared by write-one unless set this edge.
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q <= 1'b0;
                else        pend_q <= hit || (pend_q && !clr_mask[i]);
            end

            assign pend[i] = pend_q;

            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                clr_mask[i] && !hit |=> !pend_q); // R10
            AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                pend_q && !clr_mask[i] |=> pend_q); // R10
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                hit && clr_mask[i] |=> pend_q); // R10
            AST_IE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg[i].irq_en && !pend_q |=> !pend_q); // R9
            AST_INERT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
                cfg[i].trig > TRIG_BOTH && !pend_q |=> !pend_q); // R9
            AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
                cfg[i].irq_en && cfg[i].trig == TRIG_LVL_HI && level[i] |=> pend_q); // R7
        end else begin : g_idle
            assign pend[i] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_regfile.sv
// Register port: per-pin configuration words, output data, status clear
// strobes and a registered read mux. Drives the pad data and enables.
// Assumes: byte addresses; only word-aligned offsets are decoded.
module gpio_regfile
    import gpio_ctrl_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic                     rd,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [MAX_PINS-1:0]      pend,
    input  logic [MAX_PINS-1:0]      level,
    output pin_cfg_t [MAX_PINS-1:0]  cfg,
    output logic [MAX_PINS-1:0]      drv_data,
    output logic [MAX_PINS-1:0]      drv_en,
    output logic [MAX_PINS-1:0]      clr_mask
);

    localparam logic [MAX_PINS-1:0] LIVE  = pin_mask(NPIN);
    localparam int                  IDX_W = $clog2(MAX_PINS);

    logic              word_ok;
    logic              cfg_zone;
    logic [IDX_W-1:0]  sel_idx;
    logic [DATA_W-1:0] rd_val;
    logic [MAX_PINS-1:0] out_q;

    assign word_ok  = (addr[1:0] == 2'b00);
    assign cfg_zone = word_ok && !addr[ADDR_W-1];
    assign sel_idx  = addr[IDX_W+1:2];

    for (genvar i = 0; i < MAX_PINS; i++) begin : g_cfg
        if (i < NPIN) begin : g_live
            pin_cfg_t cfg_q;

            // Configuration word of this pin.
            always_ff @(posedge clk) begin
                if (!rst_n)                                       cfg_q <= '0;
                else if (wr && cfg_zone && sel_idx == IDX_W'(i))  cfg_q <= word_to_cfg(wdata);
            end

            assign cfg[i]    = cfg_q;
            assign drv_en[i] = cfg_q.out_en && cfg_q.buf_en;

            AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                wr && cfg_zone && sel_idx == IDX_W'(i) && !wdata[0] |=> !drv_en[i]); // R4
            AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
                wr && cfg_zone && sel_idx == IDX_W'(i) && wdata[0] && wdata[2] |=> drv_en[i]); // R4
        end else begin : g_idle
            assign cfg[i]    = '0;
            assign drv_en[i] = 1'b0;
        end
    end

    // Output data register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      out_q <= '0;
        else if (wr && addr == OFS_OUTVAL) out_q <= wdata & LIVE;
    end

    assign drv_data = out_q;
    assign clr_mask = (wr && addr == OFS_STATUS) ? (wdata & LIVE) : '0;

    // Read mux over all mapped offsets.
    always_comb begin
        rd_val = '0;
        if (cfg_zone) begin
            rd_val = cfg_to_word(cfg[sel_idx]);
        end else if (word_ok) begin
            case (addr)
                OFS_STATUS: rd_val = pend;
                OFS_INVAL:  rd_val = level;
                OFS_OUTVAL: rd_val = out_q;
                default:    rd_val = '0;
            endcase
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    AST_RD_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd && addr[1:0] != 2'b00 |=> rdata == '0); // R12
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R12

endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO controller top: synchronizer, trigger detection and register file.
// Assumes: PIN_REQ is limited to 1..32; unused pins are inert.
module gpio_irq_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int PIN_REQ = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [MAX_PINS-1:0] pin_in,
    output logic [MAX_PINS-1:0] pin_out,
    output logic [MAX_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int NPIN = (PIN_REQ > MAX_PINS) ? MAX_PINS : ((PIN_REQ < 1) ? 1 : PIN_REQ);

    logic [MAX_PINS-1:0]     level;
    logic [MAX_PINS-1:0]     last;
    logic [MAX_PINS-1:0]     pend;
    logic [MAX_PINS-1:0]     clr_mask;
    pin_cfg_t [MAX_PINS-1:0] cfg;

    gpio_in_sync #(.NPIN(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pin_in),
        .level_q (level),
        .last_q  (last)
    );

    gpio_event_det #(.NPIN(NPIN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .level    (level),
        .last     (last),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    gpio_regfile #(.NPIN(NPIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .pend     (pend),
        .level    (level),
        .cfg      (cfg),
        .drv_data (pin_out),
        .drv_en   (pin_oe),
        .clr_mask (clr_mask)
    );

    assign irq = |pend;

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(reg_wr && reg_addr == OFS_STATUS) |=> irq); // R11

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a cycle model built from the requirements.
module sim_gpio_irq_ctrl;

    localparam int          NP  = 24;
    localparam logic [31:0] MSK = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] pin_in = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.PIN_REQ(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- cycle model ----------------
    logic [7:0]  m_cfg [32];
    logic [31:0] m_out, m_s1, m_s2, m_prev, m_pend, m_rdata, nxt_pend;
    logic        m_rd_seen;
    logic [7:0]  m_rd_addr;

    function automatic bit trig_hit(logic [2:0] code, bit cur, bit prv);
        case (code)
            3'd0: return cur;
            3'd1: return !cur;
            3'd2: return cur && !prv;
            3'd3: return !cur && prv;
            3'd4: return cur != prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (!a[7]) return (int'(a[6:2]) < NP) ? {24'h0, m_cfg[a[6:2]]} : 32'h0;
        case (a)
            8'h80: return m_pend;
            8'h84: return m_s2;
            8'h88: return m_out;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_oe();
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = m_cfg[i][0] & m_cfg[i][2];
        return v;
    endfunction

    function automatic string tag_for(logic [7:0] a);
        if (a[1:0] != 2'b00) return "R12 unaligned read";
        if (!a[7]) return (int'(a[6:2]) < NP) ? "R3 config read" : "R2 config read";
        case (a)
            8'h80: return "R10 status read";
            8'h84: return "R6 input read";
            8'h88: return "R5 output read";
            default: return "R12 unmapped read";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_cfg[i] <= 8'h00;
            m_out <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
            m_rdata <= '0; m_rd_seen <= 1'b0; m_rd_addr <= '0;
        end else begin
            nxt_pend = '0;
            for (int i = 0; i < NP; i++) begin
                nxt_pend[i] = (m_cfg[i][3] && trig_hit(m_cfg[i][7:5], m_s2[i], m_prev[i]))
                            || (m_pend[i] && !(reg_wr && reg_addr == 8'h80 && reg_wdata[i]));
            end
            m_pend <= nxt_pend;
            m_s1 <= pin_in & MSK;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            if (reg_wr && reg_addr[1:0] == 2'b00 && !reg_addr[7] && int'(reg_addr[6:2]) < NP)
                m_cfg[reg_addr[6:2]] <= {reg_wdata[7:5], 1'b0, reg_wdata[3:0]};
            if (reg_wr && reg_addr == 8'h88) m_out <= reg_wdata & MSK;
            if (reg_rd) m_rdata <= model_read(reg_addr);
            m_rd_seen <= reg_rd;
            m_rd_addr <= reg_addr;
        end
    end

    // Continuous compare against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            check("R11 irq", {31'h0, irq}, {31'h0, |m_pend});
            check("R4 pin_oe", pin_oe, model_oe());
            check("R5 pin_out", pin_out, m_out);
            if (m_rd_seen) check(tag_for(m_rd_addr), reg_rdata, m_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'd5150);
        wait_n(3);
        check("R1 irq in reset", {31'h0, irq}, 32'h0);
        check("R1 pin_oe in reset", pin_oe, 32'h0);
        check("R1 pin_out in reset", pin_out, 32'h0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        wait_n(1);
        bus_rd(8'h88, d); check("R1 output reg", d, 32'h0);
        bus_rd(8'h80, d); check("R1 status reg", d, 32'h0);
        bus_rd(8'h00, d); check("R1 config 0", d, 32'h0);

        // R3 field layout
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_rd(8'h04, d); check("R3 reserved bits zero", d, 32'h0000_00EF);
        bus_wr(8'h04, 32'h0);

        // R4 drive needs both enables
        bus_wr(8'h08, 32'h1); check("R4 out_en only", pin_oe, 32'h0);
        bus_wr(8'h08, 32'h5); check("R4 both enables", pin_oe, 32'h4);
        bus_wr(8'h08, 32'h4); check("R4 buffer only", pin_oe, 32'h0);

        // R5 / R2 output data masked to bank width
        bus_wr(8'h88, 32'hFFFF_FFFF);
        check("R5 pin_out follows", pin_out, MSK);
        bus_rd(8'h88, d); check("R2 output mask", d, MSK);
        bus_wr(8'h88, 32'h0);

        // R6 input latency
        pin_in = 32'h0000_000F;
        bus_rd(8'h84, d); check("R6 first read old", d, 32'h0);
        bus_rd(8'h84, d); check("R6 second read old", d, 32'h0);
        bus_rd(8'h84, d); check("R6 third read new", d, 32'h0000_000F);
        pin_in = 32'h0;
        wait_n(3);

        // R7 level high, re-set after clear, set beats clear
        bus_wr(8'h0C, 32'h08);
        wait_n(2); check("R7 inactive level", {31'h0, irq}, 32'h0);
        pin_in[3] = 1'b1;
        wait_n(3); check("R11 irq on level", {31'h0, irq}, 32'h1);
        bus_rd(8'h80, d); check("R7 level high pending", d, 32'h8);
        bus_wr(8'h80, 32'h8);
        bus_rd(8'h80, d); check("R10 set wins over clear", d, 32'h8);
        pin_in[3] = 1'b0;
        wait_n(3);
        bus_wr(8'h80, 32'h8);
        bus_rd(8'h80, d); check("R10 clear after level drops", d, 32'h0);
        check("R11 irq low", {31'h0, irq}, 32'h0);
        bus_wr(8'h0C, 32'h0);

        // R7 level low, R10 zero write, R9 enable off
        bus_wr(8'h10, 32'h28);
        wait_n(1); check("R7 level low pending", {31'h0, irq}, 32'h1);
        bus_wr(8'h80, 32'h0);
        bus_rd(8'h80, d); check("R10 zero write no effect", d, 32'h10);
        bus_wr(8'h10, 32'h20);
        bus_wr(8'h80, 32'h10);
        wait_n(2);
        bus_rd(8'h80, d); check("R9 enable off", d, 32'h0);

        // R8 rising with exact latency
        bus_wr(8'h14, 32'h48);
        pin_in[5] = 1'b1;
        wait_n(2); check("R8 not yet", {31'h0, irq}, 32'h0);
        wait_n(1); check("R8 rising third edge", {31'h0, irq}, 32'h1);
        bus_wr(8'h80, 32'h20);
        wait_n(2);
        bus_rd(8'h80, d); check("R8 no re-set while high", d, 32'h0);

        // R8 falling
        bus_wr(8'h18, 32'h68);
        pin_in[6] = 1'b1;
        wait_n(4); check("R8 falling ignores rise", {31'h0, irq}, 32'h0);
        pin_in[6] = 1'b0;
        wait_n(3);
        bus_rd(8'h80, d); check("R8 falling pending", d, 32'h40);
        bus_wr(8'h80, 32'h40);

        // R8 both edges
        bus_wr(8'h1C, 32'h88);
        pin_in[7] = 1'b1;
        wait_n(3);
        bus_rd(8'h80, d); check("R8 both rise", d, 32'h80);
        bus_wr(8'h80, 32'h80);
        pin_in[7] = 1'b0;
        wait_n(3);
        bus_rd(8'h80, d); check("R8 both fall", d, 32'h80);
        bus_wr(8'h80, 32'h80);

        // R9 inert codes 5 and 7
        bus_wr(8'h20, 32'hA8);
        pin_in[8] = 1'b1; wait_n(3); pin_in[8] = 1'b0; wait_n(3);
        bus_rd(8'h80, d); check("R9 code 5 inert", d, 32'h0);
        bus_wr(8'h20, 32'hE8);
        pin_in[8] = 1'b1; wait_n(3); pin_in[8] = 1'b0; wait_n(3);
        bus_rd(8'h80, d); check("R9 code 7 inert", d, 32'h0);

        // R2 pins above bank width
        bus_wr(8'h78, 32'hFF);
        bus_rd(8'h78, d); check("R2 high config ignored", d, 32'h0);
        pin_in[28] = 1'b1;
        wait_n(3);
        bus_rd(8'h84, d); check("R2 high input masked", d & ~MSK, 32'h0);
        check("R2 high pin_oe", pin_oe & ~MSK, 32'h0);
        pin_in[28] = 1'b0;

        // R12 unmapped and unaligned
        bus_rd(8'h8C, d); check("R12 unmapped 0x8C", d, 32'h0);
        bus_rd(8'hFC, d); check("R12 unmapped 0xFC", d, 32'h0);
        bus_rd(8'h01, d); check("R12 unaligned 0x01", d, 32'h0);
        bus_wr(8'h05, 32'hFF);
        bus_rd(8'h04, d); check("R12 unaligned write ignored", d, 32'h0);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int unsigned kind;
            logic [7:0] a;
            case ($urandom % 6)
                0, 1:    a = {1'b0, 5'($urandom % 32), 2'b00};
                2:       a = 8'h80;
                3:       a = 8'h84;
                4:       a = 8'h88;
                default: a = 8'($urandom);
            endcase
            kind = $urandom % 8;
            reg_addr = a;
            reg_wdata = $urandom;
            reg_wr = (kind >= 3 && kind <= 5);
            reg_rd = (kind >= 6);
            if ($urandom % 4 == 0) pin_in = pin_in ^ (32'h1 << ($urandom % 32));
            @(negedge clk);
        end
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        wait_n(2);
        summary();
        $finish;
    end

endmodule